// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns one 32-bit product. Each word holds a sign bit, an 8-bit exponent field offset by 127, and a 23-bit fraction that sits behind an implicit leading one. The sign, exponent and significand are worked out on separate paths:

- The sign is formed by an XOR.
- The exponent field sum is formed by a generate/propagate lookahead adder, which also removes the offset.
- The 24-bit significands are multiplied in a separate multiplier unit. The 48-bit result is then normalized by at most one place and cut down to 23 fraction bits by dropping the low bits.

A small classifier marks each operand as zero, infinite or NaN. An exponent field of 0 is read as zero, so subnormal inputs are flushed. The special-case logic and the exponent range check then choose the final word and a 5-bit flag vector.

The arithmetic is combinational. A single output register stage carries a valid/ready handshake on both sides:

- An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- The result appears with `out_valid` after that same edge.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high).
- When `out_valid` is high and `out_ready` is low, the stage holds its word and flags, and `in_ready` goes low. This back-pressure stalls the producer without losing data.

Top module: `sp_fmul`

## Requirements
- R1: The product sign bit [31] is the XOR of the operand sign bits, for normal, overflowed and underflowed results alike.
- R2: For two normal operands whose significand product is below 2, the exponent field [30:23] equals Ea + Eb - 127.
- R3: When the significand product is 2 or more, it is shifted right one place and the exponent field becomes Ea + Eb - 126. This adjustment is applied before the range checks, so it can push a result into overflow or lift it out of underflow.
- R4: The fraction [22:0] is the truncated product: product bits below the kept 23 are discarded and never round the result up.
- R5: If the final exponent field would be 255 or more, the output is a signed infinity (exponent all ones, fraction zero). The flags then show infinity (bit 3) and overflow (bit 1).
- R6: If the final exponent field would be 0 or less, the output is a signed zero. The flags then show zero (bit 2) and underflow (bit 0).
- R7: If either operand is a NaN (exponent all ones, nonzero fraction), or infinity meets zero, the output is 0x7FC00000 and only the NaN flag (bit 4) is set.
- R8: Infinity times a nonzero finite value or times infinity gives a correctly signed infinity, with only flag bit 3 set and no overflow, whatever the other exponent.
- R9: An operand with exponent field 0 (zero or subnormal) times a finite value gives a signed zero, with only flag bit 2 set and no underflow.
- R10: `in_ready` is high when the output stage is empty or `out_ready` is high. An accepted pair shows up with `out_valid` after the accepting edge, and pairs can be accepted on consecutive cycles.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_flags` hold, `in_ready` is low, and offered operands are not taken.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result word held in the output stage |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Product word |
| out_flags | output | 5 | {nan, inf, zero, overflow, underflow} |

## Verification
Two paths can act on the same pair in one cycle: the special-operand override and the exponent range check. Examples are an infinity times a value with an enormous exponent, or a zero times a tiny normal; in both, the raw exponent sum leaves the range. Both paths are provoked with such pairs, and the result is judged correct only if the special result wins and the overflow and underflow flags stay clear. The normalization step is likewise paired with the range check: one pair only overflows after the one-place shift, and another is lifted out of underflow by it.

// File: rtl/sp_fmul_pkg.sv
package sp_fmul_pkg;

  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;
    logic ovf;
    logic unf;
  } fm_flags_t;

  localparam int FLAG_W = $bits(fm_flags_t);

endpackage

// File: rtl/sp_fmul_cla.sv
module sp_fmul_cla #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W:0]   c;
  logic [W-1:0] g;
  logic [W-1:0] p;

  assign c[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign g[i]   = a[i] & b[i];
      assign p[i]   = a[i] | b[i];
      assign c[i+1] = g[i] | (p[i] & c[i]);
      assign sum[i] = a[i] ^ b[i] ^ c[i];
    end
  endgenerate

  logic unused_cout;
  assign unused_cout = c[W];

endmodule

// File: rtl/sp_fmul_sigmul.sv
module sp_fmul_sigmul #(
  parameter int SIG_W = 24,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [PROD_W-1:0] prod
);

  assign prod = sig_a * sig_b;

endmodule

// File: rtl/sp_fmul_classify.sv
module sp_fmul_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W:0]   sig,
  output logic              is_zero,
  output logic              is_inf,
  output logic              is_nan
);

  logic [FRAC_W-1:0] frac;
  logic              exp_max;

  assign sign    = op[WORD_W-1];
  assign exp_f   = op[WORD_W-2 -: EXP_W];
  assign frac    = op[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign is_zero = (exp_f == '0);
  assign is_inf  = exp_max && (frac == '0);
  assign is_nan  = exp_max && (frac != '0);
  assign sig     = {1'b1, frac};

endmodule

// File: rtl/sp_fmul.sv
module sp_fmul
  import sp_fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [FLAG_W-1:0] out_flags
);

  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int SUM_W  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic [SUM_W-1:0]  NEG_BIAS = SUM_W'((1 << SUM_W) - BIAS);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // operand classification
  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [FRAC_W:0]  siga, sigb;
  logic             za, zb, ia, ib, na, nb;

  sp_fmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op(in_a), .sign(sa), .exp_f(ea), .sig(siga),
    .is_zero(za), .is_inf(ia), .is_nan(na)
  );

  sp_fmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op(in_b), .sign(sb), .exp_f(eb), .sig(sigb),
    .is_zero(zb), .is_inf(ib), .is_nan(nb)
  );

  // significand path
  logic [PROD_W-1:0] prod;
  logic              norm;
  logic [FRAC_W-1:0] frac_r;

  sp_fmul_sigmul #(.SIG_W(SIG_W)) u_sig (
    .sig_a(siga), .sig_b(sigb), .prod(prod)
  );

  assign norm   = prod[PROD_W-1];
  assign frac_r = norm ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

  logic unused_lo;
  assign unused_lo = ^prod[SIG_W-2:0];

  // exponent path: field sum, then offset removal with normalization carry-in
  logic [SUM_W-1:0] esum, eres;

  sp_fmul_cla #(.W(SUM_W)) u_cla_sum (
    .a({2'b00, ea}), .b({2'b00, eb}), .cin(1'b0), .sum(esum)
  );

  sp_fmul_cla #(.W(SUM_W)) u_cla_bias (
    .a(esum), .b(NEG_BIAS), .cin(norm), .sum(eres)
  );

  logic ovf, unf;
  assign unf = eres[SUM_W-1] || (eres == '0);
  assign ovf = !eres[SUM_W-1] && (eres >= SUM_W'(EMAX));

  // result selection
  logic              sign_r;
  logic [WORD_W-1:0] res;
  fm_flags_t         flg;

  assign sign_r = sa ^ sb;

  always_comb begin
    res = {sign_r, eres[EXP_W-1:0], frac_r};
    flg = '0;
    if (na || nb || (ia && zb) || (ib && za)) begin
      res      = QNAN;
      flg.nan  = 1'b1;
    end else if (ia || ib) begin
      res      = {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flg.inf  = 1'b1;
    end else if (za || zb) begin
      res      = {sign_r, {(WORD_W-1){1'b0}}};
      flg.zero = 1'b1;
    end else if (ovf) begin
      res      = {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flg.inf  = 1'b1;
      flg.ovf  = 1'b1;
    end else if (unf) begin
      res      = {sign_r, {(WORD_W-1){1'b0}}};
      flg.zero = 1'b1;
      flg.unf  = 1'b1;
    end
  end

  // output stage
  logic              vld_q;
  logic [WORD_W-1:0] data_q;
  fm_flags_t         flg_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      flg_q  <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= res;
        flg_q  <= flg;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_flags = flg_q;

endmodule

// File: rtl/sp_fmul_chk.sv
module sp_fmul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [4:0]        out_flags
);

  localparam logic [WORD_W-2:0] MAG_INF = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_norm, b_norm;
  assign a_norm = (in_a[WORD_W-2 -: EXP_W] != '0) && !(&in_a[WORD_W-2 -: EXP_W]);
  assign b_norm = (in_b[WORD_W-2 -: EXP_W] != '0) && !(&in_b[WORD_W-2 -: EXP_W]);

  assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && a_norm && b_norm) |=>
      (out_data[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1])));

  assert_ovf_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_flags[3] && out_data[WORD_W-2:0] == MAG_INF));

  assert_unf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[0]) |-> (out_flags[2] && out_data[WORD_W-2:0] == '0));

  assert_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[4]) |-> (out_data == QNAN && out_flags[3:0] == '0));

  assert_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_flags[4:2]));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_flags)));

endmodule

bind sp_fmul sp_fmul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_flags(out_flags)
);

// File: tb/test_sp_fmul.sv
`timescale 1ns/1ps
module test_sp_fmul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sp_fmul i_sp_fmul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flags(out_flags)
  );

  // {a, b, expected word, expected flags {nan,inf,zero,ovf,unf}, requirement}
  localparam int NV = 24;
  localparam logic [104:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 5'b00000, 4'd2},  // R2 1*1
    {32'h40000000, 32'h40400000, 32'h40C00000, 5'b00000, 4'd2},  // R2 2*3
    {32'hBFC00000, 32'h3FC00000, 32'hC0100000, 5'b00000, 4'd3},  // R3 -1.5*1.5
    {32'hC0000000, 32'hC0400000, 32'h40C00000, 5'b00000, 4'd1},  // R1 neg*neg
    {32'h3FC00001, 32'h3FC00001, 32'h40100001, 5'b00000, 4'd4},  // R4 truncation
    {32'h7F000000, 32'h40000000, 32'h7F800000, 5'b01010, 4'd5},  // R5 overflow
    {32'h7E800000, 32'h40000000, 32'h7F000000, 5'b00000, 4'd5},  // R5 largest exponent
    {32'h7F400000, 32'h3FC00000, 32'h7F800000, 5'b01010, 4'd5},  // R5 overflow via shift
    {32'h00800000, 32'h3F000000, 32'h00000000, 5'b00101, 4'd6},  // R6 underflow
    {32'h80800000, 32'h3F000000, 32'h80000000, 5'b00101, 4'd6},  // R6 signed underflow
    {32'h00800000, 32'h3F800000, 32'h00800000, 5'b00000, 4'd6},  // R6 smallest exponent
    {32'h00800000, 32'h00800000, 32'h00000000, 5'b00101, 4'd6},  // R6 negative sum
    {32'h00C00000, 32'h3F400000, 32'h00900000, 5'b00000, 4'd3},  // R3 shift lifts out of underflow
    {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 5'b10000, 4'd7},  // R7 NaN operand
    {32'h7F800000, 32'h00000000, 32'h7FC00000, 5'b10000, 4'd7},  // R7 inf*zero
    {32'hFF800001, 32'h80000000, 32'h7FC00000, 5'b10000, 4'd7},  // R7 NaN*zero
    {32'hFF800000, 32'h40000000, 32'hFF800000, 5'b01000, 4'd8},  // R8 -inf*2
    {32'h7F800000, 32'hFF800000, 32'hFF800000, 5'b01000, 4'd8},  // R8 inf*-inf
    {32'h7F800000, 32'h7F000000, 32'h7F800000, 5'b01000, 4'd8},  // R8 inf*huge, no ovf
    {32'hFF800000, 32'h00800000, 32'hFF800000, 5'b01000, 4'd8},  // R8 -inf*tiny
    {32'h80000000, 32'h40400000, 32'h80000000, 5'b00100, 4'd9},  // R9 -0*3
    {32'h00000001, 32'h3F800000, 32'h00000000, 5'b00100, 4'd9},  // R9 subnormal flushed
    {32'h00000000, 32'h00800000, 32'h00000000, 5'b00100, 4'd9},  // R9 zero*tiny, no unf
    {32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 5'b01010, 4'd5}   // R5 max*max
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R12 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_a     = VEC[i][104:73];
      in_b     = VEC[i][72:41];
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R%0d vec %0d valid", VEC[i][3:0], i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R%0d vec %0d data", VEC[i][3:0], i), out_data, VEC[i][40:9]);
      chk($sformatf("R%0d vec %0d flags", VEC[i][3:0], i), {27'd0, out_flags}, {27'd0, VEC[i][8:4]});
    end

    // R10 back-to-back acceptance
    @(negedge clk);
    out_ready = 1'b1;
    in_a = 32'h40000000; in_b = 32'h40400000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 first result", out_data, 32'h40C00000);
    chk("R10 ready while draining", {31'd0, in_ready}, 32'd1);
    in_a = 32'hBFC00000; in_b = 32'h3FC00000;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second result", out_data, 32'hC0100000);
    @(posedge clk);
    @(negedge clk);
    chk("R10 empty after drain", {31'd0, out_valid}, 32'd0);

    // R11 stall: result held, new operands refused
    out_ready = 1'b0;
    in_a = 32'h40000000; in_b = 32'h40400000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 32'h3F800000; in_b = 32'h3F800000;
    chk("R11 ready low while stalled", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 valid held", {31'd0, out_valid}, 32'd1);
    chk("R11 data held", out_data, 32'h40C00000);
    chk("R11 flags held", {27'd0, out_flags}, 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 offered pair taken on release", out_data, 32'h3F800000);
    @(posedge clk);
    @(negedge clk);
    chk("R11 only one pair taken", {31'd0, out_valid}, 32'd0);

    // R12 reset mid-stream
    in_a = 32'h40000000; in_b = 32'h40000000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset clears valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule